// File: doc/BRIEF.md
# Microsecond Timestamp and Compare Timer

This peripheral keeps a 64-bit count of elapsed microseconds. A tick enable divides the input clock, and the count advances once on each tick. Software reaches the block through a small 32-bit register bus with an address, a write strobe, a read strobe and a registered read-data return. The bus offers six words:

| Offset | Contents |
|---|---|
| 0x00 | timestamp, low half |
| 0x04 | timestamp, high half, as captured by the last low-half read |
| 0x08 | compare target, low half |
| 0x0C | compare target, high half |
| 0x10 | control |
| 0x14 | status |

To read the count, software reads the low half first. That read freezes the high half in a shadow register, and a later read of offset 0x04 returns the frozen value. The two halves therefore always belong to one count, even when a carry passes between the two reads.

For a one-shot event, software first turns compare off. It writes the target high half, then the low half, and then turns compare back on. Once the count has reached or passed the target while compare is on, a sticky event flag is set. The interrupt line follows that flag until software clears it.

Top module: `ustamp_timer`

## Requirements
- R1: Synchronous active-high reset loads the count with the START_TS parameter (zero by default). It also clears the compare target, the compare enable, the shadow half and the event flag, so every register reads back as zero and the interrupt line is low.
- R2: The count advances by exactly one on every CLKS_PER_US-th input clock and holds between ticks.
- R3: A read of offset 0x00 returns bits 31:0 of the count and captures bits 63:32 into a shadow register. A read of offset 0x04 returns that shadow, not the live upper half. Read data appears one clock after the read strobe.
- R4: The count is read-only: bus writes to offsets 0x00 and 0x04 leave it unchanged.
- R5: Offsets 0x08 and 0x0C write and read back bits 31:0 and 63:32 of the compare target.
- R6: At offset 0x10, bit 0 is compare enable and bit 1 is a write guard. A write changes bit 0 only when bit 1 of the written word is 1. The register reads back compare enable in bit 0 and zeros elsewhere.
- R7: The event flag (status offset 0x14, bit 0) is set on the first clock where compare is enabled and the count is greater than or equal to the target. A target already in the past therefore matches at once when compare is turned on.
- R8: After software clears the flag, the flag is not set again while the match condition stays true. A new event needs the condition to fall and rise again, for example by turning compare off and on.
- R9: Writing 1 to status bit 0 clears the flag and writing 0 leaves it unchanged. When a clear and a new event fall in the same clock, the event wins.
- R10: The interrupt output equals the event flag. It stays high after compare is turned off, until software clears it.
- R11: While compare is disabled the flag is never set, including with a target of zero.
- R12: A target 100 or more ticks ahead of the count at programming time always produces an event. The event comes no earlier than the count reaching the target and at most one tick after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | input clock, CLKS_PER_US cycles per microsecond |
| rst | input | 1 | synchronous active-high reset |
| bus_addr | input | ADDR_W | byte offset of the accessed register |
| bus_we | input | 1 | write strobe, one cycle per write |
| bus_rd | input | 1 | read strobe, one cycle per read |
| bus_wdata | input | 32 | write data |
| bus_rdata | output | 32 | read data, valid the cycle after bus_rd |
| irq | output | 1 | level interrupt, high while the event flag is set |

## Verification
The bench waits for a carry out of the low half and splits a 64-bit read across it. A design that returned the live upper half would show a high half of 1 next to a low half taken before the carry.

The bench places a status clear in the same clock as a new event. A design where the clear wins would lose that event. It clears the flag while the count stays above the target, so a level-triggered flag would fire again. It writes to the control word without the guard bit, which a design that ignores the guard would let through. It also programs targets a little more than 100 ticks ahead, where a comparison that is off by one or only checks equality would fire early, late or never.

// File: rtl/ustamp_pkg.sv
package ustamp_pkg;

  localparam int WORD_W = 32;
  localparam int TS_W   = 64;

  // register byte offsets; software depends on these positions
  localparam int OFS_TS_LO  = 'h00;
  localparam int OFS_TS_HI  = 'h04;
  localparam int OFS_CMP_LO = 'h08;
  localparam int OFS_CMP_HI = 'h0C;
  localparam int OFS_CTRL   = 'h10;
  localparam int OFS_STAT   = 'h14;

  // the count has reached or passed the programmed target
  function automatic logic target_reached(input logic [TS_W-1:0] ts,
                                          input logic [TS_W-1:0] tgt);
    return ts >= tgt;
  endfunction

  // guarded update of compare enable: bit 1 of the data must be set
  function automatic logic guarded_enable(input logic       cur,
                                          input logic [1:0] wd);
    return wd[1] ? wd[0] : cur;
  endfunction

  // sticky flag: a new event beats a clear request in the same cycle
  function automatic logic flag_update(input logic cur,
                                       input logic set_evt,
                                       input logic clr);
    return set_evt | (cur & ~clr);
  endfunction

endpackage

// File: rtl/ustamp_tick_gen.sv
module ustamp_tick_gen #(
  parameter int CLKS_PER_US = 50
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CNT_W = (CLKS_PER_US > 1) ? $clog2(CLKS_PER_US) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CLKS_PER_US - 1);

  generate
    if (CLKS_PER_US > 1) begin : g_div
      logic [CNT_W-1:0] div_q;

      assign tick = (div_q == LAST);

      always_ff @(posedge clk) begin
        if (rst)       div_q <= '0;
        else if (tick) div_q <= '0;
        else           div_q <= div_q + 1'b1;
      end

      // R2: two ticks never sit on adjacent clocks when dividing
      assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);
    end else begin : g_pass
      logic unused_ok;
      assign unused_ok = clk ^ rst;
      assign tick = 1'b1;
    end
  endgenerate

endmodule

// File: rtl/ustamp_counter.sv
module ustamp_counter #(
  parameter int          TS_W     = 64,
  parameter logic [63:0] START_TS = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tick,
  output logic [TS_W-1:0] ts
);
  always_ff @(posedge clk) begin
    if (rst)       ts <= TS_W'(START_TS);
    else if (tick) ts <= ts + 1'b1;
  end

  // R2: one step per tick
  assert_step_on_tick_R2: assert property (@(posedge clk) disable iff (rst)
    tick |=> ts == $past(ts) + 1'b1);

  // R4: nothing but the tick moves the count
  assert_hold_between_R4: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(ts));

endmodule

// File: rtl/ustamp_match.sv
module ustamp_match
  import ustamp_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [TS_W-1:0] ts,
  input  logic [TS_W-1:0] tgt,
  input  logic            cmp_en,
  input  logic            clr_req,
  output logic            match_evt,
  output logic            flag
);
  logic hit_now;
  logic hit_q;

  assign hit_now   = cmp_en & target_reached(ts, tgt);
  assign match_evt = hit_now & ~hit_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_q <= 1'b0;
      flag  <= 1'b0;
    end else begin
      hit_q <= hit_now;
      flag  <= flag_update(flag, match_evt, clr_req);
    end
  end

  // R7: an event always lands in the flag
  assert_event_sets_R7: assert property (@(posedge clk) disable iff (rst)
    match_evt |=> flag);

  // R9: flag is sticky unless cleared
  assert_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    (flag && !clr_req) |=> flag);

  // R9: a clear with no competing event empties the flag
  assert_clear_R9: assert property (@(posedge clk) disable iff (rst)
    (clr_req && !match_evt) |=> !flag);

  // R11: no new flag while compare is off
  assert_quiet_when_off_R11: assert property (@(posedge clk) disable iff (rst)
    !cmp_en |=> !$rose(flag));

endmodule

// File: rtl/ustamp_timer.sv
module ustamp_timer
  import ustamp_pkg::*;
#(
  parameter int          CLKS_PER_US = 50,
  parameter int          ADDR_W      = 5,
  parameter logic [63:0] START_TS    = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic              bus_rd,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq
);
  localparam int HALF = TS_W / 2;

  logic            tick;
  logic [TS_W-1:0] ts;
  logic [TS_W-1:0] tgt_q;
  logic            cmp_en_q;
  logic [HALF-1:0] shadow_hi_q;
  logic [WORD_W-1:0] rdata_q;
  logic [WORD_W-1:0] rd_mux;
  logic            flag;
  logic            match_evt;

  // named decode events
  logic sel_ts_lo, sel_ts_hi, sel_cmp_lo, sel_cmp_hi, sel_ctrl, sel_stat;
  logic wr_cmp_lo, wr_cmp_hi, wr_ctrl, clr_req, rd_snap;

  assign sel_ts_lo  = (bus_addr == ADDR_W'(OFS_TS_LO));
  assign sel_ts_hi  = (bus_addr == ADDR_W'(OFS_TS_HI));
  assign sel_cmp_lo = (bus_addr == ADDR_W'(OFS_CMP_LO));
  assign sel_cmp_hi = (bus_addr == ADDR_W'(OFS_CMP_HI));
  assign sel_ctrl   = (bus_addr == ADDR_W'(OFS_CTRL));
  assign sel_stat   = (bus_addr == ADDR_W'(OFS_STAT));

  assign wr_cmp_lo = bus_we & sel_cmp_lo;
  assign wr_cmp_hi = bus_we & sel_cmp_hi;
  assign wr_ctrl   = bus_we & sel_ctrl;
  assign clr_req   = bus_we & sel_stat & bus_wdata[0];
  assign rd_snap   = bus_rd & sel_ts_lo;

  ustamp_tick_gen #(.CLKS_PER_US(CLKS_PER_US)) u_tick (
    .clk (clk),
    .rst (rst),
    .tick(tick)
  );

  ustamp_counter #(.TS_W(TS_W), .START_TS(START_TS)) u_count (
    .clk (clk),
    .rst (rst),
    .tick(tick),
    .ts  (ts)
  );

  ustamp_match u_match (
    .clk      (clk),
    .rst      (rst),
    .ts       (ts),
    .tgt      (tgt_q),
    .cmp_en   (cmp_en_q),
    .clr_req  (clr_req),
    .match_evt(match_evt),
    .flag     (flag)
  );

  always_comb begin
    rd_mux = '0;
    unique case (1'b1)
      sel_ts_lo:  rd_mux = ts[HALF-1:0];
      sel_ts_hi:  rd_mux = shadow_hi_q;
      sel_cmp_lo: rd_mux = tgt_q[HALF-1:0];
      sel_cmp_hi: rd_mux = tgt_q[TS_W-1:HALF];
      sel_ctrl:   rd_mux = {{(WORD_W-1){1'b0}}, cmp_en_q};
      sel_stat:   rd_mux = {{(WORD_W-1){1'b0}}, flag};
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tgt_q       <= '0;
      cmp_en_q    <= 1'b0;
      shadow_hi_q <= '0;
      rdata_q     <= '0;
    end else begin
      if (wr_cmp_lo) tgt_q[HALF-1:0]    <= bus_wdata;
      if (wr_cmp_hi) tgt_q[TS_W-1:HALF] <= bus_wdata;
      if (wr_ctrl)   cmp_en_q <= guarded_enable(cmp_en_q, bus_wdata[1:0]);
      if (rd_snap)   shadow_hi_q <= ts[TS_W-1:HALF];
      if (bus_rd)    rdata_q <= rd_mux;
    end
  end

  assign bus_rdata = rdata_q;
  assign irq       = flag;

  // R3: a low-half read freezes the upper half seen at that clock
  assert_shadow_capture_R3: assert property (@(posedge clk) disable iff (rst)
    rd_snap |=> shadow_hi_q == $past(ts[TS_W-1:HALF]));

  // R3: shadow only moves on a low-half read
  assert_shadow_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !rd_snap |=> $stable(shadow_hi_q));

  // R6: an unguarded control write leaves compare enable alone
  assert_ctrl_guard_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_ctrl && !bus_wdata[1]) |=> $stable(cmp_en_q));

  // R5: target halves only change on their own writes
  assert_tgt_stable_R5: assert property (@(posedge clk) disable iff (rst)
    (!wr_cmp_lo && !wr_cmp_hi) |=> $stable(tgt_q));

endmodule

// File: tb/ustamp_timer_test.sv
module ustamp_timer_test;
  localparam int          CPU   = 4;
  localparam logic [63:0] START = 64'h0000_0000_FFFF_FF00;
  localparam logic [4:0]  A_TSL = 5'h00, A_TSH = 5'h04, A_CML = 5'h08,
                          A_CMH = 5'h0C, A_CTL = 5'h10, A_STA = 5'h14;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  addr = '0;
  logic        we = 1'b0;
  logic        rd = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  ustamp_timer #(.CLKS_PER_US(CPU), .ADDR_W(5), .START_TS(START)) uut (
    .clk(clk), .rst(rst), .bus_addr(addr), .bus_we(we), .bus_rd(rd),
    .bus_wdata(wdata), .bus_rdata(rdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_in(input string req, input logic [63:0] act,
                        input logic [63:0] lo, input logic [63:0] hi);
    checks++;
    if (act < lo || act > hi) begin
      errors++;
      $display("FAIL %s: actual %h expected %h..%h", req, act, lo, hi);
    end
  endtask

  // every bus task is entered and left just after a falling edge
  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rdw(input logic [4:0] a, output logic [31:0] v);
    addr = a; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    v = rdata;
  endtask

  task automatic rd64(output logic [63:0] v);
    logic [31:0] lo, hi;
    rdw(A_TSL, lo);
    rdw(A_TSH, hi);
    v = {hi, lo};
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rdw(A_TSL, v); chk("R1 ts low after reset", v, START[31:0]);
    rdw(A_TSH, v); chk("R1 ts high after reset", v, START[63:32]);
    rdw(A_CML, v); chk("R1 target low", v, 0);
    rdw(A_CMH, v); chk("R1 target high", v, 0);
    rdw(A_CTL, v); chk("R1 control", v, 0);
    rdw(A_STA, v); chk("R1 status", v, 0);
    chk("R1 irq", irq, 0);
  endtask

  task automatic t_rate;
    logic [31:0] a, b;
    rdw(A_TSL, a);
    idle(10 * CPU - 1);
    rdw(A_TSL, b);
    chk("R2 ten ticks in 10*CPU clocks", b - a, 10);
  endtask

  task automatic t_coherent;
    logic [31:0] v, hi;
    v = '0;
    for (int i = 0; i < 2000; i++) begin
      rdw(A_TSL, v);
      if (v >= 32'hFFFF_FFFB) break;
    end
    chk_in("R3 poll reached carry zone", v, 32'hFFFF_FFFB, 32'hFFFF_FFFF);
    idle(60);
    rdw(A_TSH, hi);
    chk("R3 shadow high kept across carry", hi, 0);
    rdw(A_TSL, v);
    chk_in("R3 low after carry", v, 0, 32'h40);
    rdw(A_TSH, hi);
    chk("R3 high after fresh low read", hi, 1);
  endtask

  task automatic t_readonly;
    logic [63:0] t0, t1;
    rd64(t0);
    wr(A_TSL, 32'h0);
    wr(A_TSH, 32'hFFFF_FFFF);
    rd64(t1);
    chk_in("R4 count unaffected by writes", t1, t0, t0 + 3);
  endtask

  task automatic t_regs;
    logic [31:0] v;
    wr(A_CMH, 32'h9ABC_DEF0);
    wr(A_CML, 32'h1234_5678);
    rdw(A_CML, v); chk("R5 target low readback", v, 32'h1234_5678);
    rdw(A_CMH, v); chk("R5 target high readback", v, 32'h9ABC_DEF0);
    wr(A_CTL, 32'h1);
    rdw(A_CTL, v); chk("R6 unguarded enable ignored", v, 0);
    wr(A_CTL, 32'h3);
    rdw(A_CTL, v); chk("R6 guarded enable, bit1 reads 0", v, 1);
    wr(A_CTL, 32'hFFFF_FFFC);
    rdw(A_CTL, v); chk("R6 unguarded disable ignored", v, 1);
    wr(A_CTL, 32'h2);
    rdw(A_CTL, v); chk("R6 guarded disable", v, 0);
    chk("R7 far target gives no event", irq, 0);
  endtask

  task automatic t_past_target;
    logic [31:0] v;
    wr(A_CMH, 0);
    wr(A_CML, 0);
    wr(A_CTL, 32'h3);
    chk("R7 flag one clock after enable", irq, 0);
    @(negedge clk);
    chk("R7 past target matches at once", irq, 1);
    rdw(A_STA, v); chk("R7 status bit0", v, 1);
  endtask

  task automatic t_edge;
    logic [31:0] v;
    wr(A_STA, 32'h1);
    idle(20);
    chk("R8 no refire while condition holds", irq, 0);
    rdw(A_STA, v); chk("R8 status stays clear", v, 0);
    wr(A_CTL, 32'h2);
    wr(A_CTL, 32'h3);
    chk("R8 rearm not yet visible", irq, 0);
    @(negedge clk);
    chk("R8 rearm after off/on fires", irq, 1);
  endtask

  task automatic t_sticky;
    logic [31:0] v;
    wr(A_CTL, 32'h2);
    idle(10);
    chk("R10 irq held after disable", irq, 1);
    rdw(A_STA, v); chk("R10 status held", v, 1);
    wr(A_STA, 32'hFFFF_FFFE);
    chk("R9 writing 0 keeps flag", irq, 1);
    wr(A_STA, 32'h1);
    chk("R9 writing 1 clears flag", irq, 0);
    wr(A_CTL, 32'h3);
    wr(A_STA, 32'h1);
    chk("R9 event beats same-clock clear", irq, 1);
    wr(A_CTL, 32'h2);
    wr(A_STA, 32'h1);
    chk("R9 cleared again", irq, 0);
  endtask

  task automatic t_disabled;
    logic [31:0] v;
    wr(A_CMH, 0);
    wr(A_CML, 0);
    wr(A_STA, 32'h1);
    idle(50);
    chk("R11 zero target while off stays quiet", irq, 0);
    wr(A_CTL, 32'h1);
    idle(10);
    chk("R11 unguarded enable does not fire", irq, 0);
    rdw(A_CTL, v); chk("R6 enable still off", v, 0);
  endtask

  task automatic t_future(input int delta);
    logic [63:0] now, tgt, t;
    int waited;
    wr(A_CTL, 32'h2);
    rd64(now);
    tgt = now + 64'(delta);
    wr(A_CMH, tgt[63:32]);
    wr(A_CML, tgt[31:0]);
    wr(A_CTL, 32'h3);
    chk("R12 no event right after enable", irq, 0);
    waited = 0;
    for (int i = 0; i < delta * CPU + 100; i++) begin
      if (irq) break;
      @(negedge clk);
      waited++;
    end
    chk("R12 future target fires", irq, 1);
    chk_in("R12 not early", 64'(waited), 64'((delta - 10) * CPU), 64'(delta * CPU + 10));
    rd64(t);
    chk_in("R12 count at event", t, tgt, tgt + 1);
    wr(A_CTL, 32'h2);
    wr(A_STA, 32'h1);
  endtask

  task automatic report;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    idle(5);
    rst = 1'b0;
    t_reset();
    t_rate();
    t_coherent();
    t_readonly();
    t_regs();
    t_past_target();
    t_edge();
    t_sticky();
    t_disabled();
    t_future(100);
    t_future(137);
    report();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    report();
    $finish;
  end

endmodule